// File: doc/BRIEF.md
# Multi-Source Reset Cause Controller

This block merges four reset requests into one system reset and records which of them caused the most recent reset. The four requests are:

- an active-low external reset pin, debounced by a synchronizer and a minimum-width filter;
- a one-cycle software reset strobe from the core;
- a watchdog time-out;
- a priority conflict between hard traps.

The watchdog path acts at once, with no clock edge in between, while the core is awake. While the core sleeps or idles, the same time-out only raises a wake-up pulse.

A 16-bit cause register holds sticky flags. A power-on reset input clears them, and the system reset it drives does not. Software clears a flag by writing a 1 to that bit. A trap monitor tracks the priority level now in service. A hard trap (levels 13 to 15) that arrives with a lower priority than the active one is a conflict and forces a reset.

Top module: `rcc_top`

## Requirements
- R1: When the external pin is held low for at least MIN_W consecutive clock samples, `sys_rst_o` is asserted and stays asserted while the pin stays low.
- R2: A low pulse on the external pin shorter than MIN_W samples causes no reset and sets no flag.
- R3: An external reset sets status bit 7.
- R4: A software strobe held for one cycle drives `sys_rst_o` high for exactly the one cycle after the next clock edge.
- R5: A software reset sets status bit 6.
- R6: A watchdog time-out while neither sleep nor idle is set drives `sys_rst_o` high in the same cycle, before any clock edge, and sets status bit 4.
- R7: A watchdog time-out while sleep or idle is set produces no reset and no bit 4. It produces a one-cycle `wake_o` pulse after the next edge.
- R8: A trap of level 13 to 15 that arrives while a trap of higher level is active causes a one-cycle reset after the next edge and sets status bit 15.
- R9: A trap is not a conflict when its level is equal to or higher than the active level, when its level is below 13, or when no trap is active. An acknowledge ends the active trap.
- R10: Status flags survive system resets. A write clears each bit written as 1. A set in the same cycle wins over a clear. Bits other than 15, 7, 6 and 4 always read 0.
- R11: While `por_i` is high, the status register, `sys_rst_o` and `wake_o` are all driven to 0 (with no watchdog request).

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| por_i | input | 1 | Power-on reset, synchronous, active high |
| ext_rst_n_i | input | 1 | Raw external reset pin, active low |
| sw_rst_i | input | 1 | Software reset strobe |
| wdt_tmo_i | input | 1 | Watchdog time-out pulse |
| sleep_i | input | 1 | Core is in sleep mode |
| idle_i | input | 1 | Core is in idle mode |
| trap_vld_i | input | 1 | Trap event valid |
| trap_lvl_i | input | 4 | Priority level of the trap event |
| trap_ack_i | input | 1 | Active trap has been serviced |
| stat_wr_i | input | 1 | Write strobe for clearing status flags |
| stat_wdata_i | input | 16 | Ones mark the flags to clear |
| sys_rst_o | output | 1 | System reset |
| wake_o | output | 1 | Wake-up pulse |
| status_o | output | 16 | Reset cause flags |

## Verification
The trap conflict is the hardest case to reach from the ports. It needs a trap at level 14 or 15 already active, and then a hard trap of strictly lower level arriving before the acknowledge. A conflict also flushes the active level, so the next trap finds the monitor empty.

The stimulus mixes directed pairs (15 then 14, 14 then 15, equal levels, 15 then 12) with a long run of random traps at levels 8 to 15 and random acknowledges. A bench model of the active level predicts, for every cycle, whether a reset and bit 15 must appear.

// File: rtl/rcc_pkg.sv
package rcc_pkg;
  localparam int STAT_W   = 16;
  localparam int LVL_W    = 4;
  localparam int BIT_TRAP = 15;
  localparam int BIT_EXT  = 7;
  localparam int BIT_SW   = 6;
  localparam int BIT_WDT  = 4;
  localparam int HARD_LO  = 13;
  localparam int HARD_HI  = 15;

  typedef struct packed {
    logic trap;
    logic ext;
    logic sw;
    logic wdt;
  } cause_t;

  function automatic logic [STAT_W-1:0] cause_to_bits(cause_t c);
    logic [STAT_W-1:0] v;
    v = '0;
    v[BIT_TRAP] = c.trap;
    v[BIT_EXT]  = c.ext;
    v[BIT_SW]   = c.sw;
    v[BIT_WDT]  = c.wdt;
    return v;
  endfunction
endpackage

// File: rtl/rcc_pin_filter.sv
module rcc_pin_filter #(
  parameter int MIN_W       = 4,
  parameter int SYNC_STAGES = 2
) (
  input  logic clk_i,
  input  logic rst_i,
  input  logic pin_n_i,
  output logic req_o
);
  localparam int CNT_W = (MIN_W < 2) ? 1 : $clog2(MIN_W + 1);
  localparam logic [CNT_W-1:0] CNT_LAST = CNT_W'(MIN_W - 1);

  logic [SYNC_STAGES-1:0] sync_q;
  logic [CNT_W-1:0]       cnt_q;
  logic                   act_q;
  logic                   low;

  generate
    if (SYNC_STAGES == 1) begin : g_one
      always_ff @(posedge clk_i) begin
        if (rst_i) sync_q <= '1;
        else       sync_q <= pin_n_i;
      end
    end else begin : g_chain
      always_ff @(posedge clk_i) begin
        if (rst_i) sync_q <= '1;
        else       sync_q <= {sync_q[SYNC_STAGES-2:0], pin_n_i};
      end
    end
  endgenerate

  assign low = ~sync_q[SYNC_STAGES-1];

  always_ff @(posedge clk_i) begin
    if (rst_i) begin
      cnt_q <= '0;
      act_q <= 1'b0;
    end else if (!low) begin
      cnt_q <= '0;
      act_q <= 1'b0;
    end else if (cnt_q == CNT_LAST) begin
      act_q <= 1'b1;
    end else begin
      cnt_q <= cnt_q + 1'b1;
    end
  end

  assign req_o = act_q;

  // R1
  filt_rise_chk: assert property (@(posedge clk_i) disable iff (rst_i)
    $rose(act_q) |-> (cnt_q == CNT_LAST));
  // R2
  filt_drop_chk: assert property (@(posedge clk_i) disable iff (rst_i)
    !low |=> !act_q);
endmodule

// File: rtl/rcc_trap_mon.sv
module rcc_trap_mon
  import rcc_pkg::*;
(
  input  logic             clk_i,
  input  logic             rst_i,
  input  logic             flush_i,
  input  logic             vld_i,
  input  logic [LVL_W-1:0] lvl_i,
  input  logic             ack_i,
  output logic             conflict_o
);
  logic             act_v_q;
  logic [LVL_W-1:0] act_lvl_q;
  logic             is_hard;
  logic             takes;

  assign is_hard    = (lvl_i >= LVL_W'(HARD_LO)) && (lvl_i <= LVL_W'(HARD_HI));
  assign conflict_o = vld_i && act_v_q && is_hard && (lvl_i < act_lvl_q) && !flush_i;
  assign takes      = vld_i && (!act_v_q || (lvl_i >= act_lvl_q));

  always_ff @(posedge clk_i) begin
    if (rst_i) begin
      act_v_q   <= 1'b0;
      act_lvl_q <= '0;
    end else if (flush_i || conflict_o) begin
      act_v_q   <= 1'b0;
      act_lvl_q <= '0;
    end else if (takes) begin
      act_v_q   <= 1'b1;
      act_lvl_q <= lvl_i;
    end else if (ack_i) begin
      act_v_q   <= 1'b0;
      act_lvl_q <= '0;
    end
  end

  // R8
  trap_flush_chk: assert property (@(posedge clk_i) disable iff (rst_i)
    conflict_o |=> !act_v_q);
  // R9
  trap_ack_chk: assert property (@(posedge clk_i) disable iff (rst_i)
    (ack_i && !vld_i) |=> !act_v_q);
endmodule

// File: rtl/rcc_status.sv
module rcc_status #(
  parameter int                  W    = 16,
  parameter logic [W-1:0]        IMPL = '1
) (
  input  logic         clk_i,
  input  logic         rst_i,
  input  logic [W-1:0] set_i,
  input  logic         clr_we_i,
  input  logic [W-1:0] clr_data_i,
  output logic [W-1:0] flags_o
);
  logic [W-1:0] flags_q;
  logic [W-1:0] clr_mask;

  assign clr_mask = clr_we_i ? clr_data_i : '0;

  always_ff @(posedge clk_i) begin
    if (rst_i) flags_q <= '0;
    else       flags_q <= ((flags_q & ~clr_mask) | set_i) & IMPL;
  end

  assign flags_o = flags_q;

  // R10
  sticky_flags_chk: assert property (@(posedge clk_i) disable iff (rst_i)
    !clr_we_i |=> (($past(flags_q) & ~flags_q) == '0));
  // R10
  unused_bits_chk: assert property (@(posedge clk_i) disable iff (rst_i)
    (flags_q & ~IMPL) == '0);
  // R10
  set_wins_chk: assert property (@(posedge clk_i) disable iff (rst_i)
    (set_i != '0) |=> ((flags_q & $past(set_i & IMPL)) == $past(set_i & IMPL)));
endmodule

// File: rtl/rcc_top.sv
module rcc_top
  import rcc_pkg::*;
#(
  parameter int MIN_W = 4
) (
  input  logic              clk_i,
  input  logic              por_i,
  input  logic              ext_rst_n_i,
  input  logic              sw_rst_i,
  input  logic              wdt_tmo_i,
  input  logic              sleep_i,
  input  logic              idle_i,
  input  logic              trap_vld_i,
  input  logic [LVL_W-1:0]  trap_lvl_i,
  input  logic              trap_ack_i,
  input  logic              stat_wr_i,
  input  logic [STAT_W-1:0] stat_wdata_i,
  output logic              sys_rst_o,
  output logic              wake_o,
  output logic [STAT_W-1:0] status_o
);
  localparam cause_t ALL_CAUSES = '{trap: 1'b1, ext: 1'b1, sw: 1'b1, wdt: 1'b1};
  localparam logic [STAT_W-1:0] IMPL = cause_to_bits(ALL_CAUSES);

  logic   ext_req;
  logic   conflict;
  logic   low_pwr;
  logic   wdt_awake;
  logic   wdt_wake;
  logic   sys_rst_q;
  logic   wake_q;
  cause_t cause;

  assign low_pwr   = sleep_i | idle_i;
  assign wdt_awake = wdt_tmo_i & ~low_pwr;
  assign wdt_wake  = wdt_tmo_i &  low_pwr;

  rcc_pin_filter #(.MIN_W(MIN_W), .SYNC_STAGES(2)) u_filt (
    .clk_i   (clk_i),
    .rst_i   (por_i),
    .pin_n_i (ext_rst_n_i),
    .req_o   (ext_req)
  );

  rcc_trap_mon u_trap (
    .clk_i      (clk_i),
    .rst_i      (por_i),
    .flush_i    (sys_rst_q),
    .vld_i      (trap_vld_i),
    .lvl_i      (trap_lvl_i),
    .ack_i      (trap_ack_i),
    .conflict_o (conflict)
  );

  always_comb begin
    cause.trap = conflict;
    cause.ext  = ext_req;
    cause.sw   = sw_rst_i;
    cause.wdt  = wdt_awake;
  end

  rcc_status #(.W(STAT_W), .IMPL(IMPL)) u_stat (
    .clk_i      (clk_i),
    .rst_i      (por_i),
    .set_i      (cause_to_bits(cause)),
    .clr_we_i   (stat_wr_i),
    .clr_data_i (stat_wdata_i),
    .flags_o    (status_o)
  );

  always_ff @(posedge clk_i) begin
    if (por_i) begin
      sys_rst_q <= 1'b0;
      wake_q    <= 1'b0;
    end else begin
      sys_rst_q <= ext_req | sw_rst_i | conflict | wdt_awake;
      wake_q    <= wdt_wake;
    end
  end

  // watchdog bypasses the register so the reset needs no clock edge
  assign sys_rst_o = sys_rst_q | wdt_awake;
  assign wake_o    = wake_q;

  // R4
  sw_rst_chk: assert property (@(posedge clk_i) disable iff (por_i)
    sw_rst_i |=> sys_rst_o);
  // R5
  sw_flag_chk: assert property (@(posedge clk_i) disable iff (por_i)
    sw_rst_i |=> status_o[BIT_SW]);
  // R6
  wdt_flag_chk: assert property (@(posedge clk_i) disable iff (por_i)
    (wdt_tmo_i && !sleep_i && !idle_i) |=> status_o[BIT_WDT]);
  // R7
  wdt_wake_chk: assert property (@(posedge clk_i) disable iff (por_i)
    (wdt_tmo_i && (sleep_i || idle_i)) |=> wake_o);
  // R8
  trap_rst_chk: assert property (@(posedge clk_i) disable iff (por_i)
    conflict |=> (sys_rst_o && status_o[BIT_TRAP]));
  // R3
  ext_flag_chk: assert property (@(posedge clk_i) disable iff (por_i)
    ext_req |=> status_o[BIT_EXT]);
endmodule

// File: tb/rcc_top_tb.sv
module rcc_top_tb;
  localparam int MIN_W = 4;

  logic        clk = 1'b0;
  logic        por = 1'b1;
  logic        ext_n = 1'b1;
  logic        sw = 1'b0;
  logic        wdt = 1'b0;
  logic        slp = 1'b0;
  logic        idl = 1'b0;
  logic        tv = 1'b0;
  logic [3:0]  tl = '0;
  logic        ta = 1'b0;
  logic        wr = 1'b0;
  logic [15:0] wd = '0;
  logic        sys_rst;
  logic        wake;
  logic [15:0] stat;

  int n_chk = 0;
  int n_bad = 0;

  // trap model
  bit       mv = 1'b0;
  bit [3:0] ml = '0;

  always #4 clk = ~clk;

  rcc_top #(.MIN_W(MIN_W)) u_dut (
    .clk_i(clk), .por_i(por), .ext_rst_n_i(ext_n), .sw_rst_i(sw),
    .wdt_tmo_i(wdt), .sleep_i(slp), .idle_i(idl), .trap_vld_i(tv),
    .trap_lvl_i(tl), .trap_ack_i(ta), .stat_wr_i(wr), .stat_wdata_i(wd),
    .sys_rst_o(sys_rst), .wake_o(wake), .status_o(stat)
  );

  task automatic chk(input bit ok, input string req, input int act, input int exp);
    n_chk++;
    if (!ok) begin
      n_bad++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  function automatic bit exp_conflict(bit v, bit [3:0] l, bit av, bit [3:0] al);
    return v && av && (l >= 4'd13) && (l < al);
  endfunction

  task automatic clear_all();
    @(negedge clk); wr = 1'b1; wd = 16'hFFFF;
    @(negedge clk); wr = 1'b0; wd = '0;
  endtask

  task automatic ext_pulse(input int len);
    bit seen = 1'b0;
    @(negedge clk); ext_n = 1'b0;
    for (int i = 0; i < len; i++) begin
      @(negedge clk); if (sys_rst) seen = 1'b1;
    end
    ext_n = 1'b1;
    for (int i = 0; i < 6; i++) begin
      @(negedge clk); if (sys_rst) seen = 1'b1;
    end
    if (len >= MIN_W) begin
      chk(seen, "R1", seen, 1);
      chk(stat[7], "R3", stat, 16'h0080);
    end else begin
      chk(!seen, "R2", seen, 0);
      chk(stat == 16'h0, "R2", stat, 0);
    end
    clear_all();
  endtask

  task automatic trap_step(input bit v, input bit [3:0] l, input bit a);
    bit e;
    @(negedge clk);
    tv = v; tl = l; ta = a;
    e = exp_conflict(v, l, mv, ml);
    if (e) begin mv = 1'b0; ml = '0; end
    else if (v && (!mv || l >= ml)) begin mv = 1'b1; ml = l; end
    else if (a) begin mv = 1'b0; ml = '0; end
    @(negedge clk);
    tv = 1'b0; ta = 1'b0;
    if (e) chk(sys_rst && stat[15], "R8", {sys_rst, stat[15]}, 3);
    else   chk(!sys_rst && !stat[15], "R9", {sys_rst, stat[15]}, 0);
    if (e) begin
      wr = 1'b1; wd = 16'h8000;
      @(negedge clk); wr = 1'b0; wd = '0;
    end
  endtask

  initial begin
    void'($urandom(32'd4242));
    repeat (3) @(negedge clk);
    // R11
    chk(stat == 16'h0 && !sys_rst && !wake, "R11", stat, 0);
    por = 1'b0;
    @(negedge clk);

    // R4 / R5
    sw = 1'b1;
    @(negedge clk); sw = 1'b0;
    chk(sys_rst, "R4", sys_rst, 1);
    chk(stat == 16'h0040, "R5", stat, 16'h0040);
    @(negedge clk);
    chk(!sys_rst, "R4", sys_rst, 0);
    // R10 sticky across reset
    chk(stat[6], "R10", stat, 16'h0040);

    // R6
    wdt = 1'b1; #1;
    chk(sys_rst, "R6", sys_rst, 1);
    @(negedge clk); wdt = 1'b0;
    chk(stat[4], "R6", stat, 16'h0050);

    // R10 write-one-to-clear only bit 6
    wr = 1'b1; wd = 16'h0040;
    @(negedge clk); wr = 1'b0; wd = '0;
    chk(stat == 16'h0010, "R10", stat, 16'h0010);
    // R10 set wins over clear
    sw = 1'b1; wr = 1'b1; wd = 16'h0040;
    @(negedge clk); sw = 1'b0; wr = 1'b0; wd = '0;
    chk(stat == 16'h0050, "R10", stat, 16'h0050);
    clear_all();
    chk(stat == 16'h0, "R10", stat, 0);

    // R7 sleep then idle
    for (int m = 0; m < 2; m++) begin
      slp = (m == 0); idl = (m == 1);
      @(negedge clk); wdt = 1'b1; #1;
      chk(!sys_rst, "R7", sys_rst, 0);
      @(negedge clk); wdt = 1'b0;
      chk(wake && !sys_rst, "R7", {wake, sys_rst}, 2);
      @(negedge clk);
      chk(!wake && stat == 16'h0, "R7", {wake, stat}, 0);
      slp = 1'b0; idl = 1'b0;
    end

    // R1 / R2 / R3 lengths around the limit
    ext_pulse(MIN_W - 1);
    ext_pulse(1);
    ext_pulse(MIN_W);
    ext_pulse(MIN_W + 5);

    // R8 / R9 directed
    trap_step(1, 4'd15, 0); trap_step(1, 4'd14, 0);
    trap_step(1, 4'd14, 0); trap_step(1, 4'd15, 0); trap_step(0, 4'd0, 1);
    trap_step(1, 4'd14, 0); trap_step(1, 4'd14, 0); trap_step(0, 4'd0, 1);
    trap_step(1, 4'd15, 0); trap_step(1, 4'd12, 0); trap_step(0, 4'd0, 1);
    trap_step(1, 4'd15, 0); trap_step(0, 4'd0, 1); trap_step(1, 4'd13, 0);
    trap_step(0, 4'd0, 1);

    // random traps
    for (int i = 0; i < 400; i++) begin
      int r;
      r = $urandom_range(0, 3);
      if (r == 0) trap_step(0, 4'd0, 1);
      else        trap_step(1, 4'($urandom_range(8, 15)), 0);
    end

    // R11 power-on clears sticky flags
    @(negedge clk); sw = 1'b1;
    @(negedge clk); sw = 1'b0; por = 1'b1;
    @(negedge clk);
    chk(stat == 16'h0 && !sys_rst, "R11", stat, 0);
    por = 1'b0;

    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
    $finish;
  end

  initial begin
    repeat (200000) @(posedge clk);
    n_bad++;
    $display("FAIL watchdog actual=timeout expected=done");
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
    $finish;
  end
endmodule